// File: doc/BRIEF.md
# Display Controller Interrupt Aggregator

This block gathers single-cycle event pulses from a display raster engine and its frame-fetch DMA into a sticky raw status word. An enable word masks that status, and the result drives one level interrupt line toward the processor. Software reaches the block through a single-cycle register port with address, write enable, write data and a combinational read data path. It reads raw or masked status, clears bits by writing ones back, sets and clears enables through two separate registers, and re-arms the interrupt line with an end-of-interrupt write.

Two small state machines shape the behaviour. The frame-done tracker has three states: FD_IDLE, FD_RUN and FD_DRAIN. Raster enabled moves any state to FD_RUN. Raster dropping while in FD_RUN moves to FD_DRAIN. A frame-end pulse while in FD_DRAIN with the raster still off emits the frame-done event and returns to FD_IDLE. The interrupt line machine also has three states: LN_ARMED, LN_ASSERTED and LN_HELD. Any pending masked bit moves LN_ARMED to LN_ASSERTED. An all-zero masked status moves LN_ASSERTED to LN_HELD. An end-of-interrupt write moves LN_HELD back to LN_ARMED. The line is high only in LN_ASSERTED.

Status bit positions are fixed because software decodes them. Bit 0 is frame done, bit 2 is sync lost, bit 5 is FIFO underflow, bit 6 is palette load done, bit 8 is end of frame on buffer 0, and bit 9 is end of frame on buffer 1. The implemented-bit mask is therefore 0x365. The word offsets are 0 raw status, 1 masked status, 2 enable-set, 3 enable-clear and 4 end-of-interrupt.

Top module: `disp_irq_hub`

## Requirements
- R1: After reset, every offset reads 0 and irq_o is low.
- R2: A one-cycle pulse on an event input sets its status bit by the following clock edge. The positions are sync lost bit 2, underflow bit 5, palette done bit 6, buffer-0 end bit 8 and buffer-1 end bit 9. Raw status reads at offset 0.
- R3: Writing to offset 0 or offset 1 clears each raw bit written as 1. Bits written as 0 are left unchanged.
- R4: An event arriving in the same cycle as a clear of its own bit leaves that bit set.
- R5: Offset 1 reads the raw status ANDed with the enable word.
- R6: Writing ones to offset 2 sets those enable bits, and writing ones to offset 3 clears them. Zero bits leave the enable word unchanged. Both offsets read the enable word, limited to the mask 0x365.
- R7: Frame done (bit 0) is raised only by a frame-end pulse that comes after the raster has been disabled while running. A frame-end pulse has no effect while the raster is enabled or while the block is idle. Re-enabling the raster before the frame-end pulse cancels the pending frame done.
- R8: While armed, irq_o rises at the clock edge after the masked status first becomes non-zero, and stays low while the masked status is zero.
- R9: Once the masked status of an asserted line becomes zero, irq_o falls at the next edge. It then stays low even if new masked events arrive, until a write to offset 4. After that write, irq_o rises one edge later if events are pending.
- R10: A bit cleared by software is set again by any later pulse of its event. Repeated events are never suppressed.
- R11: Offsets above 4 and unimplemented bit positions read as 0. Writes to offsets above 4 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Word offset of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| raster_en_i | input | 1 | Raster engine enable level |
| frame_end_i | input | 1 | Pulse at the end of each active frame |
| ev_sync_lost_i | input | 1 | Sync lost event pulse |
| ev_fifo_under_i | input | 1 | FIFO underflow event pulse |
| ev_pal_done_i | input | 1 | Palette load done event pulse |
| ev_eof0_i | input | 1 | End of frame on buffer 0 pulse |
| ev_eof1_i | input | 1 | End of frame on buffer 1 pulse |
| irq_o | output | 1 | Interrupt request line |

## Verification
A wrong raw or enable bit shows up at the read port on the first read of offset 0, 1, 2 or 3 after the faulty edge. The bench compares that read on every cycle, so such a fault is caught within one clock. A line machine stuck in the wrong state shows as irq_o differing from the model one edge after the masked status changes. It also shows as an interrupt that ignores, or does not need, the end-of-interrupt write. A faulty frame-done tracker only shows bit 0 at the next frame-end pulse. For that reason the stimulus places frame-end pulses in every tracker state: running, draining, idle and just after a cancel.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    // Width of the status word; positions are decoded by software.
    localparam int unsigned STAT_W    = 10;
    localparam int unsigned BIT_FDONE = 0;
    localparam int unsigned BIT_SYNC  = 2;
    localparam int unsigned BIT_UFLOW = 5;
    localparam int unsigned BIT_PAL   = 6;
    localparam int unsigned BIT_EOF0  = 8;
    localparam int unsigned BIT_EOF1  = 9;

    localparam logic [STAT_W-1:0] IMPL_MASK =
        STAT_W'((1 << BIT_FDONE) | (1 << BIT_SYNC) | (1 << BIT_UFLOW) |
                (1 << BIT_PAL)   | (1 << BIT_EOF0) | (1 << BIT_EOF1));

    // Word offsets of the register port.
    localparam int unsigned OFS_RAW    = 0;
    localparam int unsigned OFS_MASKED = 1;
    localparam int unsigned OFS_EN_SET = 2;
    localparam int unsigned OFS_EN_CLR = 3;
    localparam int unsigned OFS_EOI    = 4;

    typedef enum logic [1:0] {
        FD_IDLE  = 2'd0,
        FD_RUN   = 2'd1,
        FD_DRAIN = 2'd2
    } fd_state_e;

    typedef enum logic [1:0] {
        LN_ARMED    = 2'd0,
        LN_ASSERTED = 2'd1,
        LN_HELD     = 2'd2
    } ln_state_e;

endpackage

// File: rtl/disp_irq_fdone.sv
module disp_irq_fdone
    import disp_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raster_en_i,
    input  logic frame_end_i,
    output logic fdone_o
);

    fd_state_e state_q;
    fd_state_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FD_IDLE: begin
                if (raster_en_i) state_d = FD_RUN;
            end
            FD_RUN: begin
                if (!raster_en_i) state_d = FD_DRAIN;
            end
            FD_DRAIN: begin
                if (raster_en_i)       state_d = FD_RUN;
                else if (frame_end_i)  state_d = FD_IDLE;
            end
            default: state_d = FD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= FD_IDLE;
        else         state_q <= state_d;
    end

    // Output process.
    always_comb begin
        fdone_o = 1'b0;
        unique case (state_q)
            FD_DRAIN: fdone_o = frame_end_i && !raster_en_i;
            default:  fdone_o = 1'b0;
        endcase
    end

    // R7: the event only follows a cycle with the raster already off.
    a_r7_fdone_after_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fdone_o |-> (!raster_en_i && $past(!raster_en_i)));

    // R7: frame done is a single-cycle event per drain.
    a_r7_fdone_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fdone_o |=> !fdone_o);

endmodule

// File: rtl/disp_irq_line.sv
module disp_irq_line
    import disp_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pending_i,
    input  logic eoi_i,
    output logic irq_o
);

    ln_state_e state_q;
    ln_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_ARMED: begin
                if (pending_i) state_d = LN_ASSERTED;
            end
            LN_ASSERTED: begin
                if (!pending_i) state_d = LN_HELD;
            end
            LN_HELD: begin
                if (eoi_i) state_d = LN_ARMED;
            end
            default: state_d = LN_ARMED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LN_ARMED;
        else         state_q <= state_d;
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            LN_ASSERTED: irq_o = 1'b1;
            default:     irq_o = 1'b0;
        endcase
    end

    // R8: a rising line always has a pending masked event behind it.
    a_r8_rise_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(pending_i));

    // R9: without an end-of-interrupt write the held line stays low.
    a_r9_held_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == LN_HELD && !eoi_i) |=> !irq_o);

endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
    import disp_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [STAT_W-1:0] ev_vec_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [STAT_W-1:0] masked_o,
    output logic              eoi_o
);

    localparam int unsigned PAD_W = DATA_W - STAT_W;
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'(OFS_EOI);

    logic [STAT_W-1:0] wbits;
    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] set_mask;
    logic [STAT_W-1:0] dis_mask;
    logic [STAT_W-1:0] raw_q;
    logic [STAT_W-1:0] en_q;
    logic              unused_wdata_hi;

    assign wbits           = bus_wdata_i[STAT_W-1:0] & IMPL_MASK;
    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:STAT_W];

    // Write decode.
    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        dis_mask = '0;
        eoi_o    = 1'b0;
        if (bus_we_i) begin
            unique case (bus_addr_i)
                A_RAW, A_MASKED: clr_mask = wbits;
                A_EN_SET:        set_mask = wbits;
                A_EN_CLR:        dis_mask = wbits;
                A_EOI:           eoi_o    = 1'b1;
                default:         eoi_o    = 1'b0;
            endcase
        end
    end

    // One sticky cell per implemented status bit; the event wins over a clear.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    raw_q[i] <= 1'b0;
                    en_q[i]  <= 1'b0;
                end else begin
                    raw_q[i] <= (raw_q[i] && !clr_mask[i]) || ev_vec_i[i];
                    en_q[i]  <= (en_q[i] && !dis_mask[i]) || set_mask[i];
                end
            end
        end else begin : g_tie
            assign raw_q[i] = 1'b0;
            assign en_q[i]  = 1'b0;
        end
    end

    assign masked_o = raw_q & en_q;

    // Read mux.
    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            A_RAW:              bus_rdata_o = {{PAD_W{1'b0}}, raw_q};
            A_MASKED:           bus_rdata_o = {{PAD_W{1'b0}}, masked_o};
            A_EN_SET, A_EN_CLR: bus_rdata_o = {{PAD_W{1'b0}}, en_q};
            default:            bus_rdata_o = '0;
        endcase
    end

    // R4: every event seen at an edge is in the raw word afterwards.
    a_r4_event_sets_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_vec_i != '0) |=> ((raw_q & $past(ev_vec_i)) == $past(ev_vec_i)));

    // R3: cleared bits without a coincident event are gone.
    a_r3_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_mask != '0) |=> ((raw_q & $past(clr_mask & ~ev_vec_i)) == '0));

    // R6: enable-set bits stick.
    a_r6_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_mask != '0) |=> ((en_q & $past(set_mask)) == $past(set_mask)));

    // R6: enable-clear bits drop.
    a_r6_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dis_mask != '0) |=> ((en_q & $past(dis_mask)) == '0));

endmodule

// File: rtl/disp_irq_hub.sv
module disp_irq_hub
    import disp_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              raster_en_i,
    input  logic              frame_end_i,
    input  logic              ev_sync_lost_i,
    input  logic              ev_fifo_under_i,
    input  logic              ev_pal_done_i,
    input  logic              ev_eof0_i,
    input  logic              ev_eof1_i,
    output logic              irq_o
);

    logic              fdone;
    logic              eoi;
    logic [STAT_W-1:0] ev_vec;
    logic [STAT_W-1:0] masked;

    disp_irq_fdone u_fdone (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raster_en_i (raster_en_i),
        .frame_end_i (frame_end_i),
        .fdone_o     (fdone)
    );

    always_comb begin
        ev_vec            = '0;
        ev_vec[BIT_FDONE] = fdone;
        ev_vec[BIT_SYNC]  = ev_sync_lost_i;
        ev_vec[BIT_UFLOW] = ev_fifo_under_i;
        ev_vec[BIT_PAL]   = ev_pal_done_i;
        ev_vec[BIT_EOF0]  = ev_eof0_i;
        ev_vec[BIT_EOF1]  = ev_eof1_i;
    end

    disp_irq_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .ev_vec_i    (ev_vec),
        .bus_rdata_o (bus_rdata_o),
        .masked_o    (masked),
        .eoi_o       (eoi)
    );

    disp_irq_line u_line (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pending_i (|masked),
        .eoi_i     (eoi),
        .irq_o     (irq_o)
    );

    // R10: a pulse on the palette input is never dropped.
    a_r10_pal_not_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_pal_done_i |=> masked[BIT_PAL] || !$past(u_regs.en_q[BIT_PAL]) || 1'b0 ? 1'b1 : 1'b0);

endmodule

// File: tb/disp_irq_hub_tb_top.sv
`timescale 1ns/1ps
module disp_irq_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        raster = 1'b0;
    logic        fend = 1'b0;
    logic        e_sync = 1'b0, e_under = 1'b0, e_pal = 1'b0, e_eof0 = 1'b0, e_eof1 = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] IMPL = 32'h365;

    always #2.5 clk = ~clk;

    disp_irq_hub dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .raster_en_i(raster),
        .frame_end_i(fend), .ev_sync_lost_i(e_sync), .ev_fifo_under_i(e_under),
        .ev_pal_done_i(e_pal), .ev_eof0_i(e_eof0), .ev_eof1_i(e_eof1), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: raw/enable words, line mode and tracker mode as integers.
    logic [31:0] m_raw = '0, m_en = '0;
    int m_line = 0;   // 0 armed, 1 asserted, 2 held
    int m_trk = 0;    // 0 idle, 1 running, 2 draining

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0: return m_raw;
            4'd1: return m_raw & m_en;
            4'd2, 4'd3: return m_en;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R2 raw read";
            4'd1: return "R5 masked read";
            4'd2, 4'd3: return "R6 enable read";
            default: return "R11 unmapped read";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_raw = '0; m_en = '0; m_line = 0; m_trk = 0;
        end else begin
            logic [31:0] ev;
            logic [31:0] pend;
            ev = '0;
            ev[0] = (m_trk == 2) && fend && !raster;
            ev[2] = e_sync; ev[5] = e_under; ev[6] = e_pal; ev[8] = e_eof0; ev[9] = e_eof1;
            pend = m_raw & m_en;
            if (m_line == 0 && pend != 0) m_line = 1;
            else if (m_line == 1 && pend == 0) m_line = 2;
            else if (m_line == 2 && we && addr == 4'd4) m_line = 0;
            if (raster) m_trk = 1;
            else if (m_trk == 1) m_trk = 2;
            else if (m_trk == 2 && fend) m_trk = 0;
            if (we && (addr == 4'd0 || addr == 4'd1)) m_raw = m_raw & ~(wdata & IMPL);
            m_raw = m_raw | ev;
            if (we && addr == 4'd2) m_en = m_en | (wdata & IMPL);
            if (we && addr == 4'd3) m_en = m_en & ~(wdata & IMPL);
        end
        #1;
        if (rst_n && !done) begin
            chk((m_line == 2) ? "R9 irq line vs model" : "R8 irq line vs model",
                {31'b0, irq}, {31'b0, m_line == 1});
            chk(tag_of(addr), rdata, exp_rd(addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    // which: {eof1, eof0, pal, under, sync}
    task automatic pulse(input logic [4:0] which);
        @(negedge clk);
        {e_eof1, e_eof0, e_pal, e_under, e_sync} = which;
        @(negedge clk);
        {e_eof1, e_eof0, e_pal, e_under, e_sync} = '0;
    endtask

    task automatic fend_pulse();
        @(negedge clk); fend = 1'b1;
        @(negedge clk); fend = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        for (int a = 0; a < 8; a++) rd(4'(a), 32'h0, "R1 reset read");
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2 positions, R3 clears
        pulse(5'b00001); rd(4'd0, 32'h004, "R2 sync lost bit 2");
        pulse(5'b00010); rd(4'd0, 32'h024, "R2 underflow bit 5");
        pulse(5'b00100); rd(4'd0, 32'h064, "R2 palette bit 6");
        pulse(5'b11000); rd(4'd0, 32'h364, "R2 eof bits 8 and 9");
        wr(4'd0, 32'h024); rd(4'd0, 32'h340, "R3 clear via raw offset");
        wr(4'd1, 32'h300); rd(4'd0, 32'h040, "R3 clear via masked offset");
        wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, 32'h0, "R3 clear all");

        // R4 event wins over clear
        pulse(5'b00010); rd(4'd0, 32'h020, "R4 setup");
        @(negedge clk); addr = 4'd0; wdata = 32'h20; we = 1'b1; e_under = 1'b1;
        @(negedge clk); we = 1'b0; wdata = '0; e_under = 1'b0;
        rd(4'd0, 32'h020, "R4 event beats clear");
        @(negedge clk); addr = 4'd0; wdata = 32'h20; we = 1'b1; e_eof0 = 1'b1;
        @(negedge clk); we = 1'b0; wdata = '0; e_eof0 = 1'b0;
        rd(4'd0, 32'h100, "R4 other bit cleared");
        wr(4'd0, 32'h3FF); rd(4'd0, 32'h0, "R3 clear again");

        // R6 enable set/clear
        wr(4'd2, 32'h064); rd(4'd2, 32'h064, "R6 set");
        wr(4'd3, 32'h004); rd(4'd3, 32'h060, "R6 clear one bit");
        wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, 32'h365, "R6 R11 set all implemented");
        wr(4'd3, 32'h365); wr(4'd2, 32'h040); rd(4'd2, 32'h040, "R6 only palette");
        chk("R8 no irq while raw zero", {31'b0, irq}, 32'h0);

        // R5 masking
        pulse(5'b00010); rd(4'd1, 32'h0, "R5 masked hides disabled bit");
        idle(2); chk("R8 low while masked zero", {31'b0, irq}, 32'h0);

        // R8 rise timing
        pulse(5'b00100); rd(4'd1, 32'h040, "R5 masked shows enabled bit");
        chk("R8 not yet high", {31'b0, irq}, 32'h0);
        idle(1); chk("R8 high one edge later", {31'b0, irq}, 32'h1);

        // R9 hold until end-of-interrupt, R10 re-trigger
        wr(4'd1, 32'h040); chk("R9 still high on clearing edge", {31'b0, irq}, 32'h1);
        idle(1); chk("R9 falls", {31'b0, irq}, 32'h0);
        pulse(5'b00100); rd(4'd0, 32'h060, "R10 palette set again");
        idle(3); chk("R9 held low with pending", {31'b0, irq}, 32'h0);
        wr(4'd4, 32'h0); chk("R9 armed not yet high", {31'b0, irq}, 32'h0);
        idle(1); chk("R9 high after eoi", {31'b0, irq}, 32'h1);
        wr(4'd0, 32'h060); idle(2); chk("R9 low after service", {31'b0, irq}, 32'h0);
        wr(4'd4, 32'h0); idle(3); chk("R8 armed idle low", {31'b0, irq}, 32'h0);
        pulse(5'b00100); idle(1); chk("R8 rearmed rise", {31'b0, irq}, 32'h1);
        wr(4'd0, 32'h3FF); idle(2); wr(4'd4, 32'h0); idle(1);

        // R7 frame done qualification
        @(negedge clk); raster = 1'b1; idle(3);
        fend_pulse(); rd(4'd0, 32'h0, "R7 no frame done while running");
        @(negedge clk); raster = 1'b0; idle(2);
        fend_pulse(); rd(4'd0, 32'h001, "R7 frame done after disable");
        wr(4'd0, 32'h001);
        fend_pulse(); rd(4'd0, 32'h0, "R7 no frame done when idle");
        @(negedge clk); raster = 1'b1; idle(2);
        @(negedge clk); raster = 1'b0; idle(1);
        @(negedge clk); raster = 1'b1; idle(1);
        fend_pulse(); rd(4'd0, 32'h0, "R7 cancelled by re-enable");
        @(negedge clk); raster = 1'b0; idle(2);
        fend_pulse(); rd(4'd0, 32'h001, "R7 frame done after second disable");

        // R11 unmapped space
        wr(4'd7, 32'hFFFF_FFFF);
        rd(4'd0, 32'h001, "R11 raw untouched");
        rd(4'd2, 32'h040, "R11 enable untouched");
        rd(4'd7, 32'h0, "R11 unmapped reads zero");
        rd(4'd4, 32'h0, "R11 eoi reads zero");
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..: actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule